// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small pool of waiting slots placed in front of one functional unit in an out-of-order core. Dispatch writes an operation into a free slot, together with the reorder-buffer tag of the entry that will receive its result and two source operands. Each operand arrives either as a ready value, read from the register file, or as the tag of the reorder-buffer entry that will produce it, taken from the register status table.

The station watches a shared result broadcast. When a broadcast carries the tag that a waiting operand names, the slot takes that value and marks the operand ready. A slot whose operands are both ready is handed to the functional unit. The unit accepts one operation per cycle, and the slot is freed in the same cycle. A misprediction flush removes every slot whose destination belongs to instructions younger than the mispredicted branch. A full indicator stops dispatch while no slot is free.

Age is measured from the reorder-buffer head: the age of a tag t is (t - head_tag) mod 2^TAG_W. A larger age means a younger instruction.

Top module: `rs_station`

## Requirements
- R1: After reset no slot is occupied, `full` is 0 and `iss_valid` is 0.
- R2: When `alloc_valid` is 1 and a slot is free, the lowest-numbered free slot takes the operation, the destination tag and both operands at the clock edge. When `full` is 1 the allocation is dropped and has no effect.
- R3: If an occupied slot holds an operand that is not ready, and `bc_valid` is 1 with `bc_tag` equal to that operand's tag, the operand takes `bc_val` and is ready from the next cycle.
- R4: A broadcast whose tag matches a waiting operand of the allocation in the same cycle is captured into the newly written slot.
- R5: `iss_valid` is 1 only for a slot whose two operands are both ready. It rises in the cycle after the last operand becomes ready, with `iss_op`, `iss_dst`, `iss_a` and `iss_b` taken from that slot. The slot is freed at the following edge.
- R6: When several slots are ready, exactly one is issued per cycle, and it is the one with the lowest slot index.
- R7: When `flush_valid` is 1, every slot whose destination age is greater than the age of `flush_tag` is cleared at the edge and is not issued in that cycle. Slots with an equal or smaller age stay. An allocation in the same cycle whose destination is younger than `flush_tag` is dropped.
- R8: `full` is 1 exactly when every slot is occupied.
- R9: An operand that is already ready keeps its value when a broadcast carries a tag equal to its tag field, and a broadcast with a non-matching tag changes no waiting operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch writes a new operation |
| alloc_op | input | OP_W | Operation code |
| alloc_dst | input | TAG_W | Destination reorder-buffer tag |
| alloc_a_rdy | input | 1 | Source A carries a value |
| alloc_a_tag | input | TAG_W | Producer tag for source A |
| alloc_a_val | input | DATA_W | Value for source A |
| alloc_b_rdy | input | 1 | Source B carries a value |
| alloc_b_tag | input | TAG_W | Producer tag for source B |
| alloc_b_val | input | DATA_W | Value for source B |
| full | output | 1 | No free slot; dispatch must hold |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| flush_valid | input | 1 | Misprediction flush |
| flush_tag | input | TAG_W | Tag of the mispredicted branch |
| head_tag | input | TAG_W | Current oldest reorder-buffer tag |
| iss_valid | output | 1 | Operation offered to the unit |
| iss_op | output | OP_W | Issued operation code |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_a | output | DATA_W | Issued source A value |
| iss_b | output | DATA_W | Issued source B value |

## Verification
A missed capture leaves a slot waiting, so its expected issue never appears. A slot left stuck also holds `full` high after the pool should have drained. A wrong capture shows up as a wrong operand value on the first issue of that slot, one cycle after the operands complete. A flush that misses a slot, or an allocation that slips past `full`, produces an issue that the scoreboard does not expect. A priority fault changes the order of the issues, which shows in the sequence of `iss_op` values over the following cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 3;
    parameter int OP_W   = 4;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic             vld;
        logic [OP_W-1:0]  op;
        logic [TAG_W-1:0] dst;
        opnd_t            a;
        opnd_t            b;
    } slot_t;

    function automatic logic [TAG_W-1:0] rel_age(input logic [TAG_W-1:0] t,
                                                 input logic [TAG_W-1:0] h);
        return t - h;
    endfunction
endpackage

// File: rtl/rs_snoop.sv
module rs_snoop
    import rs_pkg::*;
(
    input  opnd_t             cur,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output opnd_t             nxt
);
    always_comb begin
        nxt = cur;
        if (!cur.rdy && bc_valid && (bc_tag == cur.tag)) begin
            nxt.rdy = 1'b1;
            nxt.val = bc_val;
        end
    end
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              flush_valid,
    input  logic [TAG_W-1:0]  flush_tag,
    input  logic [TAG_W-1:0]  head_tag,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);
    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
    } rs_state_t;

    rs_state_t             st_d, st_q;
    slot_t [NUM_SLOTS-1:0] slots_q;
    opnd_t [NUM_SLOTS-1:0] a_snp, b_snp;
    opnd_t                 in_a, in_b, new_a, new_b;
    logic [NUM_SLOTS-1:0]  vld_vec, kill, iss_req, iss_gnt, free_gnt;
    logic                  free_any, alloc_kill;
    logic [TAG_W-1:0]      flush_age;

    assign slots_q    = st_q.slot;
    assign in_a       = {alloc_a_rdy, alloc_a_tag, alloc_a_val};
    assign in_b       = {alloc_b_rdy, alloc_b_tag, alloc_b_val};
    assign flush_age  = rel_age(flush_tag, head_tag);
    assign alloc_kill = flush_valid && (rel_age(alloc_dst, head_tag) > flush_age);

    // per-slot operand snooping, kill and readiness
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_snoop u_snp_a (
            .cur(slots_q[g].a), .bc_valid(bc_valid), .bc_tag(bc_tag),
            .bc_val(bc_val), .nxt(a_snp[g])
        );
        rs_snoop u_snp_b (
            .cur(slots_q[g].b), .bc_valid(bc_valid), .bc_tag(bc_tag),
            .bc_val(bc_val), .nxt(b_snp[g])
        );
        assign vld_vec[g] = slots_q[g].vld;
        assign kill[g]    = flush_valid && slots_q[g].vld &&
                            (rel_age(slots_q[g].dst, head_tag) > flush_age);
        assign iss_req[g] = slots_q[g].vld && slots_q[g].a.rdy &&
                            slots_q[g].b.rdy && !kill[g];
    end

    // operands of an incoming allocation see the same broadcast
    rs_snoop u_new_a (
        .cur(in_a), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .nxt(new_a)
    );
    rs_snoop u_new_b (
        .cur(in_b), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .nxt(new_b)
    );

    rs_pick #(.N(NUM_SLOTS)) u_iss_pick  (.req(iss_req),  .gnt(iss_gnt),  .any(iss_valid));
    rs_pick #(.N(NUM_SLOTS)) u_free_pick (.req(~vld_vec), .gnt(free_gnt), .any(free_any));

    assign full = &vld_vec;

    // issue mux, grant is one-hot
    always_comb begin
        iss_op  = '0;
        iss_dst = '0;
        iss_a   = '0;
        iss_b   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (iss_gnt[i]) begin
                iss_op  = slots_q[i].op;
                iss_dst = slots_q[i].dst;
                iss_a   = slots_q[i].a.val;
                iss_b   = slots_q[i].b.val;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            st_d.slot[i].a = a_snp[i];
            st_d.slot[i].b = b_snp[i];
            if (kill[i] || iss_gnt[i]) begin
                st_d.slot[i].vld = 1'b0;
            end
        end
        if (alloc_valid && free_any && !alloc_kill) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (free_gnt[i]) begin
                    st_d.slot[i].vld = 1'b1;
                    st_d.slot[i].op  = alloc_op;
                    st_d.slot[i].dst = alloc_dst;
                    st_d.slot[i].a   = new_a;
                    st_d.slot[i].b   = new_b;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  iss_valid,
    input logic                  full,
    input logic                  bc_valid,
    input logic [TAG_W-1:0]      bc_tag,
    input logic                  flush_valid,
    input logic [TAG_W-1:0]      flush_tag,
    input logic [TAG_W-1:0]      head_tag,
    input slot_t [NUM_SLOTS-1:0] slots_q,
    input logic [NUM_SLOTS-1:0]  iss_req,
    input logic [NUM_SLOTS-1:0]  iss_gnt
);
    // R6: one grant per issue cycle
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ($countones(iss_gnt) == 1));

    // R6: no lower-indexed ready slot is passed over
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((iss_req & (iss_gnt - 1'b1)) == '0));

    // R8: with no issue and no flush, a full pool stays full
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !iss_valid && !flush_valid) |=> full);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        // R5: a granted slot is occupied with both operands ready
        a_r5_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
            iss_gnt[g] |-> (slots_q[g].vld && slots_q[g].a.rdy && slots_q[g].b.rdy));

        // R5: an issued slot is empty afterwards
        a_r5_issue_frees: assert property (@(posedge clk) disable iff (!rst_n)
            iss_gnt[g] |=> !slots_q[g].vld);

        // R3: a matching broadcast completes a waiting operand
        a_r3_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[g].vld && !slots_q[g].a.rdy && bc_valid && (bc_tag == slots_q[g].a.tag))
            |=> (!slots_q[g].vld || slots_q[g].a.rdy));

        a_r3_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
            (slots_q[g].vld && !slots_q[g].b.rdy && bc_valid && (bc_tag == slots_q[g].b.tag))
            |=> (!slots_q[g].vld || slots_q[g].b.rdy));

        // R7: younger slots are removed by a flush
        a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_valid && slots_q[g].vld &&
             (rel_age(slots_q[g].dst, head_tag) > rel_age(flush_tag, head_tag)))
            |=> !slots_q[g].vld);
    end
endmodule

bind rs_station rs_station_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .full(full),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .flush_valid(flush_valid),
    .flush_tag(flush_tag), .head_tag(head_tag), .slots_q(slots_q),
    .iss_req(iss_req), .iss_gnt(iss_gnt)
);

// File: tb/rs_station_test.sv
`timescale 1ns/1ps
module rs_station_test;
    import rs_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [OP_W-1:0]   alloc_op = '0;
    logic [TAG_W-1:0]  alloc_dst = '0;
    logic              alloc_a_rdy = 1'b0;
    logic [TAG_W-1:0]  alloc_a_tag = '0;
    logic [DATA_W-1:0] alloc_a_val = '0;
    logic              alloc_b_rdy = 1'b0;
    logic [TAG_W-1:0]  alloc_b_tag = '0;
    logic [DATA_W-1:0] alloc_b_val = '0;
    logic              full;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_val = '0;
    logic              flush_valid = 1'b0;
    logic [TAG_W-1:0]  flush_tag = '0;
    logic [TAG_W-1:0]  head_tag = '0;
    logic              iss_valid;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst;
    logic [DATA_W-1:0] iss_a, iss_b;

    always #2 clk = ~clk;

    rs_station uut (.*);

    typedef struct {
        string             req;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic check(input string req, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] want, input string what);
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
        end
    endtask

    task automatic expect_issue(input string req, input logic [OP_W-1:0] op,
                                input logic [TAG_W-1:0] dst,
                                input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        exp_t e;
        e.req = req; e.op = op; e.dst = dst; e.a = a; e.b = b;
        exp_q.push_back(e);
    endtask

    // monitor: every issue must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R5 unexpected issue op=%0d dst=%0d, expected no issue",
                         iss_op, iss_dst);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (iss_op !== e.op || iss_dst !== e.dst || iss_a !== e.a || iss_b !== e.b) begin
                    n_fail++;
                    $display("FAIL %s issue got op=%0d dst=%0d a=%0d b=%0d expected op=%0d dst=%0d a=%0d b=%0d",
                             e.req, iss_op, iss_dst, iss_a, iss_b, e.op, e.dst, e.a, e.b);
                end
            end
        end
    end

    task automatic set_alloc(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                             input logic ar, input logic [TAG_W-1:0] at, input logic [DATA_W-1:0] av,
                             input logic br, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bv);
        alloc_valid = 1'b1; alloc_op = op; alloc_dst = dst;
        alloc_a_rdy = ar; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_rdy = br; alloc_b_tag = bt; alloc_b_val = bv;
    endtask

    task automatic set_bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_val = v;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        bc_valid    = 1'b0;
        flush_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset
        check("R1", full, 1'b0, "full after reset");
        check("R1", iss_valid, 1'b0, "iss_valid after reset");

        // R2/R5: ready operands issue the cycle after allocation
        set_alloc(4'd1, 3'd1, 1'b1, 3'd0, 32'd10, 1'b1, 3'd0, 32'd20);
        expect_issue("R2", 4'd1, 3'd1, 32'd10, 32'd20);
        tick();
        idle(2);

        // R3/R9: wait on tag 5; B ready with tag field 5 must keep 7
        set_alloc(4'd2, 3'd2, 1'b0, 3'd5, 32'd0, 1'b1, 3'd5, 32'd7);
        tick();
        idle(1);
        set_bcast(3'd4, 32'd99);   // R9: non-matching tag
        tick();
        idle(1);
        set_bcast(3'd5, 32'd55);   // R3: match
        expect_issue("R3", 4'd2, 3'd2, 32'd55, 32'd7);
        tick();
        idle(2);

        // R4: broadcast in the allocation cycle
        set_alloc(4'd3, 3'd3, 1'b0, 3'd6, 32'd0, 1'b0, 3'd6, 32'd0);
        set_bcast(3'd6, 32'd66);
        expect_issue("R4", 4'd3, 3'd3, 32'd66, 32'd66);
        tick();
        idle(2);

        // R8/R2/R6: fill the pool, allocation while full is dropped
        for (int i = 0; i < 4; i++) begin
            set_alloc(4'(4 + i), 3'(1 + i), 1'b0, 3'd7, 32'd0, 1'b1, 3'd0, 32'(100 + i));
            tick();
        end
        check("R8", full, 1'b1, "full with four waiting slots");
        set_alloc(4'd9, 3'd5, 1'b1, 3'd0, 32'd1, 1'b1, 3'd0, 32'd2);  // R2: dropped
        tick();
        check("R2", full, 1'b1, "full after dropped allocation");
        set_bcast(3'd7, 32'd70);
        for (int i = 0; i < 4; i++)
            expect_issue("R6", 4'(4 + i), 3'(1 + i), 32'd70, 32'(100 + i));
        tick();
        idle(5);
        check("R8", full, 1'b0, "full after drain");
        check("R6", iss_valid, 1'b0, "iss_valid after drain");

        // R7: flush with head 0, branch tag 2 kills dst 3
        head_tag = 3'd0;
        set_alloc(4'd10, 3'd1, 1'b0, 3'd7, 32'd0, 1'b1, 3'd0, 32'd1); tick();
        set_alloc(4'd11, 3'd2, 1'b0, 3'd7, 32'd0, 1'b1, 3'd0, 32'd2); tick();
        set_alloc(4'd12, 3'd3, 1'b0, 3'd7, 32'd0, 1'b1, 3'd0, 32'd3); tick();
        flush_valid = 1'b1; flush_tag = 3'd2;
        tick();
        set_bcast(3'd7, 32'd77);
        expect_issue("R7", 4'd10, 3'd1, 32'd77, 32'd1);
        expect_issue("R7", 4'd11, 3'd2, 32'd77, 32'd2);
        tick();
        idle(4);
        check("R7", full, 1'b0, "full after flush drain");

        // R7: wrapped ages, head 6, branch tag 7; same-cycle younger allocation dropped
        head_tag = 3'd6;
        set_alloc(4'd13, 3'd7, 1'b0, 3'd5, 32'd0, 1'b1, 3'd0, 32'd13); tick();
        set_alloc(4'd14, 3'd0, 1'b0, 3'd5, 32'd0, 1'b1, 3'd0, 32'd14); tick();
        set_alloc(4'd15, 3'd1, 1'b0, 3'd5, 32'd0, 1'b1, 3'd0, 32'd15); tick();
        flush_valid = 1'b1; flush_tag = 3'd7;
        set_alloc(4'd8, 3'd2, 1'b1, 3'd0, 32'd8, 1'b1, 3'd0, 32'd8);
        tick();
        set_bcast(3'd5, 32'd50);
        expect_issue("R7", 4'd13, 3'd7, 32'd50, 32'd13);
        tick();
        idle(4);

        check("R5", 32'(exp_q.size()), 32'd0, "outstanding expected issues");
        finish_run();
    end
endmodule